// File: doc/BRIEF.md
# USB Endpoint Mode Response Controller

This block sits beside the serial interface engine of a low-speed USB function and runs one endpoint. It keeps a 4-bit endpoint mode, a received byte count, a data-valid flag, a data-toggle bit and three PID status flags (Setup, In, Out). It is fed already-checked token and packet events. From the current mode and each event it picks the reply to the host: ACK, NAK, STALL, IN data, or no reply at all.

When a transaction ends in an ACK, the hardware rewrites the mode itself. A Setup sends the endpoint to the NAK-all mode. The other accepting modes move to their NAK follow-on mode. An interrupt pulse tells firmware that the transaction completed.

So that firmware cannot overwrite these hardware changes without first seeing them, the block locks the mode and count registers against CPU writes after every ACKed transaction. Firmware clears the lock with a read once the transaction has finished, normally at the start of its interrupt handler.

Top module: `usb_ep_mode_ctrl`

## Requirements
- R1: After reset the mode is 0000 (disabled), the lock is clear and no handshake, transmit or interrupt pulse is active. In mode 0000 every token is ignored: no handshake, no transmit, no interrupt.
- R2: Token PID codes are 01 Setup, 10 In and 11 Out. The modes 0001, 0010, 0011, 1011 and 1110 accept Setup. A Setup followed by a valid data packet is ACKed, the mode becomes 0001, and the count and DTOG take the received values.
- R3: After an ACKed transaction the mode moves to its NAK follow-on: 1001 to 1000, 1101 to 1100, and 0010 or 1110 to 0001.
- R4: A data packet is valid only if its count, CRC included, is at most 10 and its error flag is low. An invalid packet gets no handshake and no interrupt, and the mode and count do not change.
- R5: The modes 1000, 1001, 1100 and 1101 ignore Setup. The OUT modes 1000 and 1001 ignore In. The IN modes 1100 and 1101 ignore Out.
- R6: In mode 0010 an Out is ACKed only if its data packet has count 2 (zero data bytes) and DTOG 1; any other valid Out is STALLed. An In in mode 0010 is STALLed.
- R7: Valid Outs get NAK in 0001, 1011 and 1000, and STALL in 0011 and 1110. Ins get NAK in 0001, 1011 and 1100, and STALL in 0011.
- R8: An In in mode 1101 or 1110 raises tx_en_o for one cycle on the following cycle; tx_zlp_o is also high in 1110. host_ack_i then completes the transaction as ACKed. host_timeout_i abandons it with no interrupt and no mode change.
- R9: The Setup PID flag sets on the cycle after an accepted Setup token, before its data packet. The In and Out PID flags update when the transaction completes, and each completion clears the other flags.
- R10: irq_o pulses for one cycle after each completed transaction (a handshake sent, or host_ack_i received) and after buf_corrupt_i.
- R11: The lock sets with every ACKed transaction. While it is set, CPU writes to the mode or count are dropped. In the cycle of an ACKed completion the hardware update wins over a CPU write.
- R12: cpu_rd_i clears the lock only when no transaction is in progress. A read during the token-to-completion window, including the completion cycle itself, leaves the lock set.
- R13: Handshake codes on hs_sel_o are 01 ACK, 10 NAK and 11 STALL. hs_valid_o pulses for one cycle, on the cycle after the data-done strobe (Setup/Out) or after the token (In).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tok_valid_i | input | 1 | Decoded token strobe |
| tok_pid_i | input | 2 | Token PID: 01 Setup, 10 In, 11 Out |
| data_done_i | input | 1 | Data packet received strobe |
| data_cnt_i | input | CNT_W | Received byte count including CRC |
| data_err_i | input | 1 | Packet failed an error check |
| data_tog_i | input | 1 | Received data toggle |
| host_ack_i | input | 1 | Host ACK received after IN data |
| host_timeout_i | input | 1 | Host ACK window closed with no ACK |
| buf_corrupt_i | input | 1 | Data buffer found corrupted |
| cpu_rd_i | input | 1 | CPU read of mode/count registers |
| cpu_wr_mode_i | input | 1 | CPU write strobe for mode |
| cpu_wmode_i | input | 4 | CPU mode write data |
| cpu_wr_cnt_i | input | 1 | CPU write strobe for count and toggle |
| cpu_wcnt_i | input | CNT_W | CPU count write data |
| cpu_wtog_i | input | 1 | CPU toggle write data |
| hs_valid_o | output | 1 | Handshake send pulse |
| hs_sel_o | output | 2 | Handshake select: 01 ACK, 10 NAK, 11 STALL |
| tx_en_o | output | 1 | Start IN data transmission |
| tx_zlp_o | output | 1 | IN data is zero length |
| irq_o | output | 1 | Interrupt pulse |
| mode_o | output | 4 | Endpoint mode |
| count_o | output | CNT_W | Byte count register |
| dval_o | output | 1 | Received data valid |
| dtog_o | output | 1 | Data toggle register |
| pid_setup_o | output | 1 | Setup PID status |
| pid_in_o | output | 1 | In PID status |
| pid_out_o | output | 1 | Out PID status |
| lock_o | output | 1 | CPU write lock |

## Verification
The hazard is a firmware access that lands in the cycle the engine completes an ACKed transaction. The unlocking read has no effect there, and the mode write loses to the hardware follow-on. The bench provokes this by driving data_done_i together with cpu_rd_i and a cpu_wr_mode_i carrying a different mode. It then requires an ACK handshake, the follow-on mode rather than the written one, and a lock that stays set. A separate case issues the read between token and data packet and requires the lock to survive it as well.

// File: rtl/usb_ep_pkg.sv
`timescale 1ns/1ps
package usb_ep_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [1:0] {PID_NONE = 2'd0, PID_SETUP = 2'd1, PID_IN = 2'd2, PID_OUT = 2'd3} pid_e;
  typedef enum logic [1:0] {HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3} hs_e;

  localparam logic [MODE_W-1:0] M_DIS       = 4'b0000;
  localparam logic [MODE_W-1:0] M_NAK_ALL   = 4'b0001;
  localparam logic [MODE_W-1:0] M_STAT_OUT  = 4'b0010;
  localparam logic [MODE_W-1:0] M_STALL_ALL = 4'b0011;
  localparam logic [MODE_W-1:0] M_SETUP     = 4'b1011;
  localparam logic [MODE_W-1:0] M_OUT_NAK   = 4'b1000;
  localparam logic [MODE_W-1:0] M_OUT_ACK   = 4'b1001;
  localparam logic [MODE_W-1:0] M_IN_NAK    = 4'b1100;
  localparam logic [MODE_W-1:0] M_IN_ACK    = 4'b1101;
  localparam logic [MODE_W-1:0] M_STAT_IN   = 4'b1110;

  typedef struct packed {
    logic accept;
    hs_e  hs;
    logic tx;
    logic zlp;
  } resp_t;

  function automatic logic [MODE_W-1:0] follow_on(logic [MODE_W-1:0] m, pid_e p);
    if (p == PID_SETUP) return M_NAK_ALL;
    case (m)
      M_OUT_ACK:             return M_OUT_NAK;
      M_IN_ACK:              return M_IN_NAK;
      M_STAT_OUT, M_STAT_IN: return M_NAK_ALL;
      default:               return m;
    endcase
  endfunction
endpackage

// File: rtl/ep_resp_decode.sv
`timescale 1ns/1ps
module ep_resp_decode
  import usb_ep_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 10,
  parameter int ZLP_CNT = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  pid_e              pid_i,
  input  logic              data_ph_i,
  input  logic [CNT_W-1:0]  dcnt_i,
  input  logic              derr_i,
  input  logic              dtog_i,
  output resp_t             resp_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CNT);
  localparam logic [CNT_W-1:0] ZLP_C = CNT_W'(ZLP_CNT);

  logic dok, stat_ok, ctl_ep, out_ep, in_ep;

  always_comb begin
    dok     = !derr_i && (dcnt_i <= MAX_C);
    stat_ok = (dcnt_i == ZLP_C) && dtog_i;
    ctl_ep  = (mode_i == M_NAK_ALL) || (mode_i == M_STAT_OUT) || (mode_i == M_STALL_ALL) ||
              (mode_i == M_SETUP) || (mode_i == M_STAT_IN);
    out_ep  = (mode_i == M_OUT_NAK) || (mode_i == M_OUT_ACK);
    in_ep   = (mode_i == M_IN_NAK) || (mode_i == M_IN_ACK);
    resp_o  = '0;
    case (pid_i)
      PID_SETUP: if (ctl_ep) begin
        if (!data_ph_i) resp_o.accept = 1'b1;
        else if (dok) begin
          resp_o.accept = 1'b1;
          resp_o.hs     = HS_ACK;
        end
      end
      PID_OUT: if (ctl_ep || out_ep) begin
        if (!data_ph_i) resp_o.accept = 1'b1;
        else if (dok) begin
          resp_o.accept = 1'b1;
          case (mode_i)
            M_OUT_ACK:              resp_o.hs = HS_ACK;
            M_STAT_OUT:             resp_o.hs = stat_ok ? HS_ACK : HS_STALL;
            M_STALL_ALL, M_STAT_IN: resp_o.hs = HS_STALL;
            default:                resp_o.hs = HS_NAK;
          endcase
        end
      end
      PID_IN: if (ctl_ep || in_ep) begin
        resp_o.accept = 1'b1;
        case (mode_i)
          M_IN_ACK:                resp_o.tx = 1'b1;
          M_STAT_IN: begin
            resp_o.tx  = 1'b1;
            resp_o.zlp = 1'b1;
          end
          M_STAT_OUT, M_STALL_ALL: resp_o.hs = HS_STALL;
          default:                 resp_o.hs = HS_NAK;
        endcase
      end
      default: resp_o = '0;
    endcase
  end
endmodule

// File: rtl/ep_xact_seq.sv
`timescale 1ns/1ps
module ep_xact_seq
  import usb_ep_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tok_valid_i,
  input  pid_e  tok_pid_i,
  input  logic  data_done_i,
  input  logic  host_ack_i,
  input  logic  host_timeout_i,
  input  logic  buf_corrupt_i,
  input  resp_t resp_i,
  output pid_e  dec_pid_o,
  output logic  dec_data_ph_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  done_ack_o,
  output logic  setup_start_o,
  output logic  hs_valid_o,
  output hs_e   hs_sel_o,
  output logic  tx_en_o,
  output logic  tx_zlp_o,
  output logic  irq_o
);
  typedef enum logic [1:0] {S_IDLE, S_DATA, S_INWAIT} state_e;

  state_e state_q, state_d;
  pid_e   pid_q;
  hs_e    hs_d;
  logic   tx_d, zlp_d;

  assign dec_pid_o     = tok_valid_i ? tok_pid_i : pid_q;
  assign dec_data_ph_o = !tok_valid_i && (state_q == S_DATA);
  assign busy_o        = (state_q != S_IDLE);

  always_comb begin
    state_d       = state_q;
    done_o        = 1'b0;
    done_ack_o    = 1'b0;
    setup_start_o = 1'b0;
    hs_d          = HS_NONE;
    tx_d          = 1'b0;
    zlp_d         = 1'b0;
    if (tok_valid_i) begin
      // a new token always restarts the sequence
      state_d = S_IDLE;
      if (resp_i.accept) begin
        case (tok_pid_i)
          PID_SETUP: begin
            state_d       = S_DATA;
            setup_start_o = 1'b1;
          end
          PID_OUT: state_d = S_DATA;
          PID_IN: begin
            if (resp_i.tx) begin
              state_d = S_INWAIT;
              tx_d    = 1'b1;
              zlp_d   = resp_i.zlp;
            end else begin
              hs_d   = resp_i.hs;
              done_o = 1'b1;
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
    end else begin
      case (state_q)
        S_DATA: if (data_done_i) begin
          state_d = S_IDLE;
          if (resp_i.accept) begin
            hs_d       = resp_i.hs;
            done_o     = 1'b1;
            done_ack_o = (resp_i.hs == HS_ACK);
          end
        end
        S_INWAIT: begin
          if (host_ack_i) begin
            state_d    = S_IDLE;
            done_o     = 1'b1;
            done_ack_o = 1'b1;
          end else if (host_timeout_i) begin
            state_d = S_IDLE;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pid_q      <= PID_NONE;
      hs_valid_o <= 1'b0;
      hs_sel_o   <= HS_NONE;
      tx_en_o    <= 1'b0;
      tx_zlp_o   <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (tok_valid_i) pid_q <= tok_pid_i;
      hs_valid_o <= (hs_d != HS_NONE);
      hs_sel_o   <= hs_d;
      tx_en_o    <= tx_d;
      tx_zlp_o   <= zlp_d;
      irq_o      <= done_o || buf_corrupt_i;
    end
  end
endmodule

// File: rtl/ep_reg_file.sv
`timescale 1ns/1ps
module ep_reg_file
  import usb_ep_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              ack_i,
  input  pid_e              pid_i,
  input  logic              setup_start_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              rx_tog_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_mode_i,
  input  logic [MODE_W-1:0] cpu_wmode_i,
  input  logic              cpu_wr_cnt_i,
  input  logic [CNT_W-1:0]  cpu_wcnt_i,
  input  logic              cpu_wtog_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              dval_o,
  output logic              dtog_o,
  output logic              pid_setup_o,
  output logic              pid_in_o,
  output logic              pid_out_o,
  output logic              lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= M_DIS;
      count_o <= '0;
      dval_o  <= 1'b0;
      dtog_o  <= 1'b0;
      lock_o  <= 1'b0;
    end else begin
      if (ack_i) begin
        mode_o <= follow_on(mode_o, pid_i);
        if (pid_i != PID_IN) begin
          count_o <= rx_cnt_i;
          dtog_o  <= rx_tog_i;
          dval_o  <= 1'b1;
        end
      end else if (!lock_o) begin
        if (cpu_wr_mode_i) mode_o <= cpu_wmode_i;
        if (cpu_wr_cnt_i) begin
          count_o <= cpu_wcnt_i;
          dtog_o  <= cpu_wtog_i;
          dval_o  <= 1'b0;
        end
      end
      if (ack_i) lock_o <= 1'b1;
      else if (cpu_rd_i && !busy_i) lock_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_setup_o <= 1'b0;
      pid_in_o    <= 1'b0;
      pid_out_o   <= 1'b0;
    end else if (setup_start_i) begin
      pid_setup_o <= 1'b1;
      pid_in_o    <= 1'b0;
      pid_out_o   <= 1'b0;
    end else if (done_i && (pid_i != PID_SETUP)) begin
      pid_setup_o <= 1'b0;
      pid_in_o    <= (pid_i == PID_IN);
      pid_out_o   <= (pid_i == PID_OUT);
    end
  end
endmodule

// File: rtl/usb_ep_mode_ctrl.sv
`timescale 1ns/1ps
module usb_ep_mode_ctrl
  import usb_ep_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 10,
  parameter int ZLP_CNT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  input  logic [1:0]       tok_pid_i,
  input  logic             data_done_i,
  input  logic [CNT_W-1:0] data_cnt_i,
  input  logic             data_err_i,
  input  logic             data_tog_i,
  input  logic             host_ack_i,
  input  logic             host_timeout_i,
  input  logic             buf_corrupt_i,
  input  logic             cpu_rd_i,
  input  logic             cpu_wr_mode_i,
  input  logic [3:0]       cpu_wmode_i,
  input  logic             cpu_wr_cnt_i,
  input  logic [CNT_W-1:0] cpu_wcnt_i,
  input  logic             cpu_wtog_i,
  output logic             hs_valid_o,
  output logic [1:0]       hs_sel_o,
  output logic             tx_en_o,
  output logic             tx_zlp_o,
  output logic             irq_o,
  output logic [3:0]       mode_o,
  output logic [CNT_W-1:0] count_o,
  output logic             dval_o,
  output logic             dtog_o,
  output logic             pid_setup_o,
  output logic             pid_in_o,
  output logic             pid_out_o,
  output logic             lock_o
);
  pid_e  dec_pid;
  logic  dec_data_ph, busy, done, done_ack, setup_start;
  resp_t resp;
  hs_e   hs_sel;

  ep_resp_decode #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .ZLP_CNT(ZLP_CNT)) u_dec (
    .mode_i    (mode_o),
    .pid_i     (dec_pid),
    .data_ph_i (dec_data_ph),
    .dcnt_i    (data_cnt_i),
    .derr_i    (data_err_i),
    .dtog_i    (data_tog_i),
    .resp_o    (resp)
  );

  ep_xact_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tok_valid_i   (tok_valid_i),
    .tok_pid_i     (pid_e'(tok_pid_i)),
    .data_done_i   (data_done_i),
    .host_ack_i    (host_ack_i),
    .host_timeout_i(host_timeout_i),
    .buf_corrupt_i (buf_corrupt_i),
    .resp_i        (resp),
    .dec_pid_o     (dec_pid),
    .dec_data_ph_o (dec_data_ph),
    .busy_o        (busy),
    .done_o        (done),
    .done_ack_o    (done_ack),
    .setup_start_o (setup_start),
    .hs_valid_o    (hs_valid_o),
    .hs_sel_o      (hs_sel),
    .tx_en_o       (tx_en_o),
    .tx_zlp_o      (tx_zlp_o),
    .irq_o         (irq_o)
  );

  assign hs_sel_o = hs_sel;

  ep_reg_file #(.CNT_W(CNT_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_i        (done),
    .ack_i         (done_ack),
    .pid_i         (dec_pid),
    .setup_start_i (setup_start),
    .busy_i        (busy),
    .rx_cnt_i      (data_cnt_i),
    .rx_tog_i      (data_tog_i),
    .cpu_rd_i      (cpu_rd_i),
    .cpu_wr_mode_i (cpu_wr_mode_i),
    .cpu_wmode_i   (cpu_wmode_i),
    .cpu_wr_cnt_i  (cpu_wr_cnt_i),
    .cpu_wcnt_i    (cpu_wcnt_i),
    .cpu_wtog_i    (cpu_wtog_i),
    .mode_o        (mode_o),
    .count_o       (count_o),
    .dval_o        (dval_o),
    .dtog_o        (dtog_o),
    .pid_setup_o   (pid_setup_o),
    .pid_in_o      (pid_in_o),
    .pid_out_o     (pid_out_o),
    .lock_o        (lock_o)
  );
endmodule

// File: rtl/usb_ep_mode_ctrl_chk.sv
`timescale 1ns/1ps
module usb_ep_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tok_valid_i,
  input logic       data_done_i,
  input logic       data_err_i,
  input logic       host_ack_i,
  input logic       buf_corrupt_i,
  input logic       cpu_wr_mode_i,
  input logic       hs_valid_o,
  input logic [1:0] hs_sel_o,
  input logic       tx_en_o,
  input logic       irq_o,
  input logic [3:0] mode_o,
  input logic       pid_setup_o,
  input logic       lock_o
);
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 4'b0000 |=> !hs_valid_o && !tx_en_o);  // R1
  AST_SETUP_TO_NAK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o && hs_sel_o == 2'b01 && pid_setup_o |-> mode_o == 4'b0001);  // R2
  AST_INVALID_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done_i && data_err_i && !tok_valid_i && !host_ack_i && !buf_corrupt_i |=> !irq_o);  // R4
  AST_TX_NO_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> !hs_valid_o);  // R8
  AST_HS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> irq_o);  // R10
  AST_ACK_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o && hs_sel_o == 2'b01 |-> lock_o);  // R11
  AST_LOCK_HOLDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && cpu_wr_mode_i |=> $stable(mode_o));  // R11
endmodule

bind usb_ep_mode_ctrl usb_ep_mode_ctrl_chk u_chk (.*);

// File: tb/usb_ep_mode_ctrl_test.sv
`timescale 1ns/1ps
module usb_ep_mode_ctrl_test;
  localparam int CNT_W = 4;
  localparam logic [1:0] SETUP = 2'b01, IN = 2'b10, OUT = 2'b11;
  localparam int ACK = 1, NAK = 2, STALL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 0, data_done = 0, data_err = 0, data_tog = 0;
  logic host_ack = 0, host_timeout = 0, buf_corrupt = 0;
  logic cpu_rd = 0, cpu_wr_mode = 0, cpu_wr_cnt = 0, cpu_wtog = 0;
  logic [1:0] tok_pid = 0;
  logic [3:0] data_cnt = 0, cpu_wmode = 0, cpu_wcnt = 0;
  logic hs_valid, tx_en, tx_zlp, irq, dval, dtog, pid_setup, pid_in, pid_out, lock;
  logic [1:0] hs_sel;
  logic [3:0] mode, count;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  usb_ep_mode_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tok_valid_i(tok_valid), .tok_pid_i(tok_pid),
    .data_done_i(data_done), .data_cnt_i(data_cnt), .data_err_i(data_err), .data_tog_i(data_tog),
    .host_ack_i(host_ack), .host_timeout_i(host_timeout), .buf_corrupt_i(buf_corrupt),
    .cpu_rd_i(cpu_rd), .cpu_wr_mode_i(cpu_wr_mode), .cpu_wmode_i(cpu_wmode),
    .cpu_wr_cnt_i(cpu_wr_cnt), .cpu_wcnt_i(cpu_wcnt), .cpu_wtog_i(cpu_wtog),
    .hs_valid_o(hs_valid), .hs_sel_o(hs_sel), .tx_en_o(tx_en), .tx_zlp_o(tx_zlp), .irq_o(irq),
    .mode_o(mode), .count_o(count), .dval_o(dval), .dtog_o(dtog),
    .pid_setup_o(pid_setup), .pid_in_o(pid_in), .pid_out_o(pid_out), .lock_o(lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic token(input logic [1:0] p);
    tok_valid = 1; tok_pid = p; step(); tok_valid = 0; tok_pid = 0;
  endtask

  task automatic data(input int cnt, input bit err, input bit tog);
    data_done = 1; data_cnt = 4'(cnt); data_err = err; data_tog = tog;
    step(); data_done = 0; data_err = 0;
  endtask

  task automatic cpu_read();
    cpu_rd = 1; step(); cpu_rd = 0;
  endtask

  task automatic cpu_mode(input logic [3:0] m);
    cpu_wr_mode = 1; cpu_wmode = m; step(); cpu_wr_mode = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    cpu_read(); cpu_mode(m);
  endtask

  function automatic int hs_code();
    return hs_valid ? int'(hs_sel) : 0;
  endfunction

  task automatic t_reset();
    chk_eq("R1 reset mode", int'(mode), 0);
    chk_eq("R1 reset lock", int'(lock), 0);
    chk_eq("R1 reset pulses", int'({hs_valid, tx_en, irq}), 0);
  endtask

  task automatic t_disabled();
    token(IN);
    chk_eq("R1 disabled IN", int'({hs_valid, tx_en}), 0);
    token(SETUP); data(2, 0, 0);
    chk_eq("R1 disabled SETUP hs/irq", int'({hs_valid, irq}), 0);
  endtask

  task automatic t_setup();
    set_mode(4'b1011);
    token(SETUP);
    chk_eq("R9 setup flag at data phase", int'(pid_setup), 1);
    data(10, 0, 0);
    chk_eq("R2 setup ACK", hs_code(), ACK);
    chk_eq("R13 handshake is ACK code", int'(hs_sel), 1);
    chk_eq("R2 mode forced 0001", int'(mode), 1);
    chk_eq("R2 count captured", int'(count), 10);
    chk_eq("R11 lock set", int'(lock), 1);
    chk_eq("R10 irq", int'(irq), 1);
    step();
    chk_eq("R13 one-cycle pulse", int'({hs_valid, irq}), 0);
  endtask

  task automatic t_lock();
    cpu_mode(4'b1001);
    chk_eq("R11 write dropped", int'(mode), 1);
    cpu_read();
    chk_eq("R12 read unlocks", int'(lock), 0);
    cpu_mode(4'b1001);
    chk_eq("R11 write after unlock", int'(mode), 9);
  endtask

  task automatic t_out_ack();
    token(OUT); data(6, 0, 1);
    chk_eq("R3 OUT ACK", hs_code(), ACK);
    chk_eq("R3 1001->1000", int'(mode), 8);
    chk_eq("R9 pid_out/pid_setup", int'({pid_out, pid_setup}), 2);
    chk_eq("R2 count/dtog/dval", int'({count, dtog, dval}), (6 << 2) | 3);
    token(OUT);
    cpu_read();
    chk_eq("R12 read while busy keeps lock", int'(lock), 1);
    data(4, 0, 0);
    chk_eq("R7 1000 NAKs OUT", hs_code(), NAK);
    chk_eq("R7 count unchanged on NAK", int'(count), 6);
    cpu_read();
    chk_eq("R12 read after completion unlocks", int'(lock), 0);
  endtask

  task automatic t_conflict();
    set_mode(4'b1001);
    token(OUT);
    data_done = 1; data_cnt = 3; data_tog = 0;
    cpu_rd = 1; cpu_wr_mode = 1; cpu_wmode = 4'b0011;
    step();
    data_done = 0; cpu_rd = 0; cpu_wr_mode = 0;
    chk_eq("R11 same-cycle ACK", hs_code(), ACK);
    chk_eq("R11 hardware wins over write", int'(mode), 8);
    chk_eq("R12 completion-cycle read keeps lock", int'(lock), 1);
  endtask

  task automatic t_validity();
    set_mode(4'b1001);
    token(OUT); data(11, 0, 0);
    chk_eq("R4 count 11 ignored", int'({hs_valid, irq}), 0);
    token(OUT); data(5, 1, 0);
    chk_eq("R4 error ignored", int'({hs_valid, irq}), 0);
    chk_eq("R4 mode unchanged", int'(mode), 9);
  endtask

  task automatic t_ignore();
    token(SETUP); data(2, 0, 0);
    chk_eq("R5 1001 ignores SETUP", int'({hs_valid, pid_setup}), 0);
    token(IN);
    chk_eq("R5 1001 ignores IN", int'({hs_valid, tx_en}), 0);
    set_mode(4'b1101);
    token(OUT); data(2, 0, 0);
    chk_eq("R5 1101 ignores OUT", int'({hs_valid, irq}), 0);
  endtask

  task automatic t_in_data();
    token(IN);
    chk_eq("R8 tx_en/zlp", int'({tx_en, tx_zlp, hs_valid}), 4);
    host_ack = 1; step(); host_ack = 0;
    chk_eq("R8 host ACK irq", int'(irq), 1);
    chk_eq("R3 1101->1100", int'(mode), 12);
    chk_eq("R9 pid_in", int'(pid_in), 1);
    token(IN);
    chk_eq("R7 1100 NAKs IN", hs_code(), NAK);
    set_mode(4'b1101);
    token(IN);
    host_timeout = 1; step(); host_timeout = 0;
    chk_eq("R8 timeout no irq/mode", int'({irq, mode}), 13);
    set_mode(4'b1110);
    token(IN);
    chk_eq("R8 zero-length IN", int'({tx_en, tx_zlp}), 3);
    host_ack = 1; step(); host_ack = 0;
    chk_eq("R3 1110->0001", int'(mode), 1);
  endtask

  task automatic t_status_out();
    set_mode(4'b0010);
    token(OUT); data(2, 0, 1);
    chk_eq("R6 status OUT ok", hs_code(), ACK);
    chk_eq("R3 0010->0001", int'(mode), 1);
    set_mode(4'b0010);
    token(OUT); data(2, 0, 0);
    chk_eq("R6 DTOG 0 stalls", hs_code(), STALL);
    token(OUT); data(3, 0, 1);
    chk_eq("R6 nonzero length stalls", hs_code(), STALL);
    chk_eq("R6 mode kept", int'(mode), 2);
    token(IN);
    chk_eq("R6 IN stalls", hs_code(), STALL);
  endtask

  task automatic t_stall_nak();
    set_mode(4'b0011);
    token(IN);
    chk_eq("R7 0011 stalls IN", hs_code(), STALL);
    token(OUT); data(4, 0, 0);
    chk_eq("R7 0011 stalls OUT", hs_code(), STALL);
    set_mode(4'b0001);
    token(IN);
    chk_eq("R7 0001 NAKs IN", hs_code(), NAK);
  endtask

  task automatic t_corrupt();
    buf_corrupt = 1; step(); buf_corrupt = 0;
    chk_eq("R10 corrupt irq", int'(irq), 1);
    step();
    chk_eq("R10 irq pulse ends", int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_disabled();
    t_setup();
    t_lock();
    t_out_ack();
    t_conflict();
    t_validity();
    t_ignore();
    t_in_data();
    t_status_out();
    t_stall_nak();
    t_corrupt();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule